// File: doc/BRIEF.md
# Multi-cycle integer processor core

This core executes a small 32-bit integer instruction set one instruction at a time. It keeps no pipeline and no overlap. Each instruction walks through a fixed series of clock cycles: fetch, decode with register read, execute or address generation, memory access or branch resolution, and (for loads only) a separate register write-back. Between cycles the values live in internal holding registers: the instruction word, the incremented program counter, two operands, the extended immediate, the branch condition, the ALU result and the loaded data.

Instruction words come from a read-only word port addressed by the program counter. Data traffic goes over a second word port with separate read and write strobes. Both ports are combinational on the read side: the returned word must be valid in the same cycle as the address. A halt instruction stops the sequencer and raises a done flag, which stays high until reset.

Top module: `mc_core`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0, clears all 32 registers, drops done and both data strobes, and starts a fetch from address 0 in the first cycle after reset is released.
- R2: Field layout, with bit 31 as the most significant bit: opcode in [31:26], first source register in [25:21], and [20:16] holding the second source for register-register instructions and the destination for all others. Register-register instructions take the destination from [15:11] and an 11-bit function code from [10:0]. The 16-bit immediate in [15:0] is sign-extended to 32 bits before use.
- R3: Opcode 0x00 performs a register-register operation chosen by the function code: 0x001 add, 0x002 subtract, 0x003 and, 0x004 or, 0x005 xor. The result is written to [15:11] and the instruction takes 4 cycles.
- R4: Opcodes 0x08 add, 0x09 subtract, 0x0A and, 0x0B or and 0x0C xor combine the first source with the sign-extended immediate and write to [20:16]. Each takes 4 cycles.
- R5: Load word (opcode 0x23) raises the read strobe only in its 4th cycle, addressed by first source plus sign-extended immediate. It writes the returned word to [20:16] and takes 5 cycles.
- R6: Store word (opcode 0x2B) raises the write strobe only in its 4th cycle at first source plus sign-extended immediate, with the register at [20:16] as write data. It takes 4 cycles.
- R7: Opcode 0x04 branches when the first source equals zero and opcode 0x05 when it is nonzero. The target is the instruction address + 4 + the sign-extended immediate as a byte offset. Otherwise execution continues at address + 4. Each takes 4 cycles.
- R8: Every non-branch, non-halt instruction continues at its own address + 4. The program counter changes only at the end of an instruction's 4th cycle, and the fetch address equals it.
- R9: Register 0 always reads as zero, and writes to it are discarded.
- R10: Opcode 0x3F halts after its fetch and decode cycles. From then on done stays high, the fetch address holds the halt's address and no data strobe is raised, until reset.
- R11: Any other opcode, and opcode 0x00 with any other function code, is a 4-cycle no-op. It writes no register and raises no strobe.
- R12: The read and write strobes are never high together, and either is high only in the cycle that follows an execute cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Instruction fetch byte address (program counter) |
| imem_rdata | input | 32 | Instruction word at imem_addr, same cycle |
| dmem_addr | output | 32 | Data byte address |
| dmem_wdata | output | 32 | Store data |
| dmem_rdata | input | 32 | Load data at dmem_addr, same cycle |
| dmem_re | output | 1 | Data read strobe |
| dmem_we | output | 1 | Data write strobe |
| done | output | 1 | High once a halt instruction has retired |

## Verification
On every cycle, the in-RTL assertions check the following: the two data strobes are exclusive and follow an execute cycle, a load's read is followed by its write-back cycle, the program counter moves only at the end of a memory cycle, register 0 is never a write target, and done is sticky and quiet. Only the bench's scenarios can show that each opcode and function code computes the right value. The same holds for immediates being sign-extended in both arithmetic and addresses, branches being taken or not on the right condition (forward and backward), and skipped or unknown instructions leaving no trace. The bench shows these through a behavioural instruction-level model that predicts the fetch address, strobes, address and write data cycle by cycle, and through the final contents of data memory.

// File: rtl/mc_core_pkg.sv
package mc_core_pkg;

    localparam int XLEN = 32;
    localparam int RAW  = 5;
    localparam int OPW  = 6;
    localparam int FNW  = 11;
    localparam int IMMW = 16;

    // LSB-numbered field positions derived from the widths
    localparam int OP_LSB  = XLEN - OPW;
    localparam int RS1_LSB = OP_LSB - RAW;
    localparam int RS2_LSB = RS1_LSB - RAW;
    localparam int RDR_LSB = RS2_LSB - RAW;

    typedef logic [XLEN-1:0] word_t;
    typedef logic [RAW-1:0]  raddr_t;

    localparam word_t INSN_BYTES = word_t'(4);

    localparam logic [OPW-1:0] OPC_REG  = 6'h00;
    localparam logic [OPW-1:0] OPC_BRZ  = 6'h04;
    localparam logic [OPW-1:0] OPC_BRNZ = 6'h05;
    localparam logic [OPW-1:0] OPC_ADDI = 6'h08;
    localparam logic [OPW-1:0] OPC_SUBI = 6'h09;
    localparam logic [OPW-1:0] OPC_ANDI = 6'h0A;
    localparam logic [OPW-1:0] OPC_ORI  = 6'h0B;
    localparam logic [OPW-1:0] OPC_XORI = 6'h0C;
    localparam logic [OPW-1:0] OPC_LDW  = 6'h23;
    localparam logic [OPW-1:0] OPC_STW  = 6'h2B;
    localparam logic [OPW-1:0] OPC_STOP = 6'h3F;

    localparam logic [FNW-1:0] FN_ADD = 11'h001;
    localparam logic [FNW-1:0] FN_SUB = 11'h002;
    localparam logic [FNW-1:0] FN_AND = 11'h003;
    localparam logic [FNW-1:0] FN_OR  = 11'h004;
    localparam logic [FNW-1:0] FN_XOR = 11'h005;

    typedef enum logic [2:0] {
        S_IF, S_ID, S_EX, S_MEM, S_WB, S_HALT
    } state_e;

    typedef enum logic [2:0] {
        C_NOP, C_RR, C_RI, C_LD, C_ST, C_BR, C_HALT
    } iclass_e;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR
    } alu_op_e;

    typedef struct packed {
        iclass_e           cls;
        alu_op_e           op;
        logic              br_ne;
        raddr_t            rs1;
        raddr_t            rs2;
        raddr_t            rd;
        logic [IMMW-1:0]   imm;
    } dec_t;

    typedef struct packed {
        word_t pc;
        word_t npc;
        word_t ir;
        word_t a;
        word_t b;
        word_t imm;
        word_t alu;
        word_t lmd;
        logic  cond;
    } dp_t;

    function automatic word_t sext16(input logic [IMMW-1:0] v);
        return {{(XLEN-IMMW){v[IMMW-1]}}, v};
    endfunction

    function automatic dec_t decode(input word_t ir);
        dec_t d;
        d.cls   = C_NOP;
        d.op    = ALU_ADD;
        d.br_ne = 1'b0;
        d.rs1   = ir[RS1_LSB +: RAW];
        d.rs2   = ir[RS2_LSB +: RAW];
        d.rd    = ir[RS2_LSB +: RAW];
        d.imm   = ir[IMMW-1:0];
        unique case (ir[OP_LSB +: OPW])
            OPC_REG: begin
                d.rd  = ir[RDR_LSB +: RAW];
                d.cls = C_RR;
                unique case (ir[FNW-1:0])
                    FN_ADD:  d.op = ALU_ADD;
                    FN_SUB:  d.op = ALU_SUB;
                    FN_AND:  d.op = ALU_AND;
                    FN_OR:   d.op = ALU_OR;
                    FN_XOR:  d.op = ALU_XOR;
                    default: d.cls = C_NOP;
                endcase
            end
            OPC_ADDI: begin d.cls = C_RI; d.op = ALU_ADD; end
            OPC_SUBI: begin d.cls = C_RI; d.op = ALU_SUB; end
            OPC_ANDI: begin d.cls = C_RI; d.op = ALU_AND; end
            OPC_ORI:  begin d.cls = C_RI; d.op = ALU_OR;  end
            OPC_XORI: begin d.cls = C_RI; d.op = ALU_XOR; end
            OPC_LDW:  d.cls = C_LD;
            OPC_STW:  d.cls = C_ST;
            OPC_BRZ:  d.cls = C_BR;
            OPC_BRNZ: begin d.cls = C_BR; d.br_ne = 1'b1; end
            OPC_STOP: d.cls = C_HALT;
            default:  d.cls = C_NOP;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/mc_decode.sv
module mc_decode
    import mc_core_pkg::*;
(
    input  word_t ir,
    output dec_t  dec
);
    always_comb dec = decode(ir);
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile
    import mc_core_pkg::*;
#(
    parameter int AW = RAW,
    parameter int W  = XLEN
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);
    localparam int NREG = 1 << AW;

    logic [W-1:0] regs_q [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
        end else if (we) begin
            regs_q[wa] <= wd;
        end
    end

    assign rd_a = regs_q[ra_a];
    assign rd_b = regs_q[ra_b];

    // R9: the sequencer must never target entry zero
    p_no_zero_write_r9: assert property (@(posedge clk) disable iff (rst)
        we |-> (wa != '0));
endmodule

// File: rtl/mc_alu.sv
module mc_alu
    import mc_core_pkg::*;
(
    input  alu_op_e op,
    input  word_t   a,
    input  word_t   b,
    output word_t   y
);
    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_XOR: y = a ^ b;
            default: y = a + b;
        endcase
    end
endmodule

// File: rtl/mc_seq.sv
module mc_seq
    import mc_core_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  dec_t   dec,
    output state_e state_o,
    output logic   rf_we_o
);
    state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IF:   state_d = S_ID;
            S_ID:   state_d = (dec.cls == C_HALT) ? S_HALT : S_EX;
            S_EX:   state_d = S_MEM;
            S_MEM:  state_d = (dec.cls == C_LD) ? S_WB : S_IF;
            S_WB:   state_d = S_IF;
            S_HALT: state_d = S_HALT;
            default: state_d = S_IF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IF;
        else     state_q <= state_d;
    end

    logic alu_wb;
    assign alu_wb  = (state_q == S_MEM) && ((dec.cls == C_RR) || (dec.cls == C_RI));
    assign rf_we_o = (alu_wb || (state_q == S_WB)) && (dec.rd != '0);
    assign state_o = state_q;
endmodule

// File: rtl/mc_core.sv
module mc_core
    import mc_core_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
    input  logic        clk,
    input  logic        rst,
    output logic [31:0] imem_addr,
    input  logic [31:0] imem_rdata,
    output logic [31:0] dmem_addr,
    output logic [31:0] dmem_wdata,
    input  logic [31:0] dmem_rdata,
    output logic        dmem_re,
    output logic        dmem_we,
    output logic        done
);
    dp_t    dp_q;
    dec_t   dec;
    state_e state_q;
    logic   rf_we;
    word_t  rf_a, rf_b, rf_wd;
    word_t  alu_a, alu_b, alu_y;

    mc_decode u_dec (
        .ir  (dp_q.ir),
        .dec (dec)
    );

    mc_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .dec     (dec),
        .state_o (state_q),
        .rf_we_o (rf_we)
    );

    assign rf_wd = (state_q == S_WB) ? dp_q.lmd : dp_q.alu;

    mc_regfile #(.AW(RAW), .W(XLEN)) u_rf (
        .clk  (clk),
        .rst  (rst),
        .ra_a (dec.rs1),
        .ra_b (dec.rs2),
        .rd_a (rf_a),
        .rd_b (rf_b),
        .we   (rf_we),
        .wa   (dec.rd),
        .wd   (rf_wd)
    );

    // operand selection for the execute cycle
    always_comb begin
        alu_a = dp_q.a;
        alu_b = dp_q.imm;
        unique case (dec.cls)
            C_RR:    alu_b = dp_q.b;
            C_BR:    alu_a = dp_q.npc;
            default: ;
        endcase
    end

    mc_alu u_alu (
        .op (dec.op),
        .a  (alu_a),
        .b  (alu_b),
        .y  (alu_y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dp_q    <= '0;
            dp_q.pc <= RESET_PC;
        end else begin
            unique case (state_q)
                S_IF: begin
                    dp_q.ir  <= imem_rdata;
                    dp_q.npc <= dp_q.pc + INSN_BYTES;
                end
                S_ID: begin
                    dp_q.a   <= rf_a;
                    dp_q.b   <= rf_b;
                    dp_q.imm <= sext16(dec.imm);
                end
                S_EX: begin
                    dp_q.alu  <= alu_y;
                    dp_q.cond <= dec.br_ne ? (dp_q.a != '0) : (dp_q.a == '0);
                end
                S_MEM: begin
                    if (dec.cls == C_LD) dp_q.lmd <= dmem_rdata;
                    dp_q.pc <= ((dec.cls == C_BR) && dp_q.cond) ? dp_q.alu : dp_q.npc;
                end
                default: ;
            endcase
        end
    end

    assign imem_addr  = dp_q.pc;
    assign dmem_addr  = dp_q.alu;
    assign dmem_wdata = dp_q.b;
    assign dmem_re    = (state_q == S_MEM) && (dec.cls == C_LD);
    assign dmem_we    = (state_q == S_MEM) && (dec.cls == C_ST);
    assign done       = (state_q == S_HALT);

    // R12: strobes exclusive
    p_strobe_excl_r12: assert property (@(posedge clk) disable iff (rst)
        !(dmem_re && dmem_we));

    // R12: a strobe only in the cycle after execute
    p_strobe_after_ex_r12: assert property (@(posedge clk) disable iff (rst)
        (dmem_re || dmem_we) |-> ($past(state_q) == S_EX));

    // R5: a read is followed by the write-back cycle
    p_load_wb_r5: assert property (@(posedge clk) disable iff (rst)
        dmem_re |=> (state_q == S_WB));

    // R8: program counter moves only at the end of the memory cycle
    p_pc_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q != S_MEM) |=> $stable(imem_addr));

    // R10: done is sticky and quiet
    p_done_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> done);
    p_done_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> (!dmem_re && !dmem_we));
endmodule

// File: tb/mc_core_tb.sv
`timescale 1ns/1ps
module mc_core_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_rdata;
    logic [31:0] dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_re, dmem_we, done;

    always #10 clk = ~clk;

    mc_core dut_i (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_rdata (dmem_rdata),
        .dmem_re    (dmem_re),
        .dmem_we    (dmem_we),
        .done       (done)
    );

    // opcode / function values from the requirements
    localparam logic [5:0] K_REG = 6'h00, K_BRZ = 6'h04, K_BRNZ = 6'h05;
    localparam logic [5:0] K_ADDI = 6'h08, K_SUBI = 6'h09, K_ANDI = 6'h0A;
    localparam logic [5:0] K_ORI = 6'h0B, K_XORI = 6'h0C;
    localparam logic [5:0] K_LW = 6'h23, K_SW = 6'h2B, K_HLT = 6'h3F;

    logic [31:0] imem    [64];
    logic [31:0] bus_mem [128];
    logic [31:0] m_mem   [128];
    logic [31:0] m_regs  [32];

    assign imem_rdata = imem[imem_addr[7:2]];
    assign dmem_rdata = bus_mem[dmem_addr[8:2]];
    always @(posedge clk) if (dmem_we) bus_mem[dmem_addr[8:2]] <= dmem_wdata;

    int n_checks = 0;
    int n_fail   = 0;
    int n_put    = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_r(input int s1, input int s2, input int d, input int fn);
        return {K_REG, s1[4:0], s2[4:0], d[4:0], fn[10:0]};
    endfunction
    function automatic logic [31:0] enc_i(input logic [5:0] op, input int s1, input int d, input int imm);
        return {op, s1[4:0], d[4:0], imm[15:0]};
    endfunction
    task automatic put(input logic [31:0] w);
        imem[n_put] = w;
        n_put++;
    endtask
    task automatic preset(input int idx, input logic [31:0] v);
        bus_mem[idx] = v;
        m_mem[idx]   = v;
    endtask

    // behavioural instruction-level reference model, stepped per cycle
    logic [31:0] m_pc, m_ir, m_ea, m_a, m_b, m_sx, m_nxt;
    int          m_phase, m_len;
    bit          m_halted;
    bit          exp_re, exp_we;

    task automatic m_wr(input logic [4:0] r, input logic [31:0] v);
        if (r != 5'd0) m_regs[r] = v;
    endtask

    always @(negedge clk) begin
        if (rst) begin
            m_pc = 0; m_phase = 0; m_halted = 0; m_len = 4;
            for (int i = 0; i < 32; i++) m_regs[i] = 0;
        end else if (m_halted) begin
            chk(done === 1'b1, "R10", "done while halted", {31'd0, done}, 32'd1);
            chk(!dmem_re && !dmem_we, "R10", "strobes while halted",
                {30'd0, dmem_re, dmem_we}, 32'd0);
            chk(imem_addr === m_pc, "R10", "pc held at halt", imem_addr, m_pc);
        end else begin
            if (m_phase == 0) begin
                m_ir  = imem[m_pc[7:2]];
                m_len = (m_ir[31:26] == K_LW) ? 5 : (m_ir[31:26] == K_HLT) ? 2 : 4;
                chk(imem_addr === m_pc, "R8", "fetch address", imem_addr, m_pc);
            end
            chk(done === 1'b0, "R10", "done before halt", {31'd0, done}, 32'd0);
            m_a   = m_regs[m_ir[25:21]];
            m_b   = m_regs[m_ir[20:16]];
            m_sx  = {{16{m_ir[15]}}, m_ir[15:0]};
            m_ea  = m_a + m_sx;
            exp_re = (m_ir[31:26] == K_LW) && (m_phase == 3);
            exp_we = (m_ir[31:26] == K_SW) && (m_phase == 3);
            chk(!(dmem_re && dmem_we), "R12", "both strobes",
                {30'd0, dmem_re, dmem_we}, 32'd0);
            chk(dmem_re === exp_re, "R5", "read strobe", {31'd0, dmem_re}, {31'd0, exp_re});
            chk(dmem_we === exp_we, "R6", "write strobe", {31'd0, dmem_we}, {31'd0, exp_we});
            if (exp_re) chk(dmem_addr === m_ea, "R5", "load address", dmem_addr, m_ea);
            if (exp_we) begin
                chk(dmem_addr === m_ea, "R6", "store address", dmem_addr, m_ea);
                chk(dmem_wdata === m_b, "R6", "store data", dmem_wdata, m_b);
            end
            if (m_phase == m_len - 1) begin
                m_nxt = m_pc + 4;
                case (m_ir[31:26])
                    K_REG: case (m_ir[10:0])
                        11'h001: m_wr(m_ir[15:11], m_a + m_b);
                        11'h002: m_wr(m_ir[15:11], m_a - m_b);
                        11'h003: m_wr(m_ir[15:11], m_a & m_b);
                        11'h004: m_wr(m_ir[15:11], m_a | m_b);
                        11'h005: m_wr(m_ir[15:11], m_a ^ m_b);
                        default: ;
                    endcase
                    K_ADDI: m_wr(m_ir[20:16], m_a + m_sx);
                    K_SUBI: m_wr(m_ir[20:16], m_a - m_sx);
                    K_ANDI: m_wr(m_ir[20:16], m_a & m_sx);
                    K_ORI:  m_wr(m_ir[20:16], m_a | m_sx);
                    K_XORI: m_wr(m_ir[20:16], m_a ^ m_sx);
                    K_LW:   m_wr(m_ir[20:16], m_mem[m_ea[8:2]]);
                    K_SW:   m_mem[m_ea[8:2]] = m_b;
                    K_BRZ:  if (m_a == 0) m_nxt = m_pc + 4 + m_sx;
                    K_BRNZ: if (m_a != 0) m_nxt = m_pc + 4 + m_sx;
                    K_HLT:  begin m_halted = 1; m_nxt = m_pc; end
                    default: ;
                endcase
                m_pc    = m_nxt;
                m_phase = 0;
            end else begin
                m_phase++;
            end
        end
    end

    task automatic run_to_done(output bit ok);
        ok = 0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (done) begin ok = 1; break; end
        end
        if (!ok) begin
            n_checks++; n_fail++;
            $display("FAIL R10 watchdog actual=%h expected=%h", 32'd0, 32'd1);
        end
    endtask

    task automatic mchk(input string tag, input int idx, input logic [31:0] exp);
        chk(bus_mem[idx] === exp, tag, $sformatf("mem[%0d]", idx), bus_mem[idx], exp);
    endtask

    bit fin_ok;

    initial begin
        for (int i = 0; i < 64; i++) imem[i] = 32'd0;
        for (int i = 0; i < 128; i++) begin bus_mem[i] = 32'd0; m_mem[i] = 32'd0; end
        preset(74, 32'h0000_DEAD);
        preset(75, 32'h1111_1111);
        preset(78, 32'h2222_2222);
        preset(79, 32'h1234_5678);
        preset(83, 32'hAAAA_5555);

        put(enc_i(K_ADDI, 0, 1, 5));
        put(enc_i(K_ADDI, 0, 2, -3));
        put(enc_r(1, 2, 3, 1));
        put(enc_r(1, 2, 4, 2));
        put(enc_r(1, 2, 5, 3));
        put(enc_r(1, 2, 6, 4));
        put(enc_r(1, 2, 7, 5));
        put(enc_i(K_XORI, 1, 8, 'hF0));
        put(enc_i(K_ANDI, 2, 9, 'h7FFF));
        put(enc_i(K_ORI, 0, 10, -16));
        put(enc_i(K_SUBI, 1, 11, 7));
        for (int r = 3; r <= 11; r++) put(enc_i(K_SW, 0, r, 'h100 + 4 * (r - 3)));
        put(enc_i(K_ADDI, 1, 0, 9));
        put(enc_i(K_SW, 0, 0, 'h128));
        put(enc_i(K_LW, 0, 12, 'h104));
        put(enc_r(12, 12, 13, 1));
        put(enc_i(K_SW, 0, 13, 'h124));
        put(enc_i(K_BRZ, 0, 0, 4));
        put(enc_i(K_ADDI, 0, 14, 1));
        put(enc_i(K_BRNZ, 0, 0, 4));
        put(enc_i(K_ADDI, 0, 15, 2));
        put(enc_i(K_ADDI, 0, 16, 3));
        put(enc_i(K_ADDI, 17, 17, 1));
        put(enc_i(K_SUBI, 16, 16, 1));
        put(enc_i(K_BRNZ, 16, 0, -12));
        put(32'hF800_0000);
        put(enc_r(1, 1, 18, 'h7FF));
        put(enc_i(K_SW, 0, 14, 'h12C));
        put(enc_i(K_SW, 0, 15, 'h130));
        put(enc_i(K_SW, 0, 17, 'h134));
        put(enc_i(K_SW, 0, 18, 'h138));
        put(enc_i(K_LW, 0, 19, 'h13C));
        put(enc_i(K_ADDI, 0, 20, 'h200));
        put(enc_i(K_LW, 20, 21, -'hC4));
        put(enc_i(K_SW, 0, 19, 'h140));
        put(enc_i(K_SW, 0, 21, 'h144));
        put(enc_i(K_BRZ, 1, 0, 4));
        put(enc_i(K_ADDI, 0, 22, 7));
        put(enc_i(K_BRNZ, 1, 0, 4));
        put(enc_i(K_ADDI, 0, 23, 9));
        put(enc_i(K_SW, 0, 22, 'h148));
        put(enc_i(K_SW, 0, 23, 'h14C));
        put({K_HLT, 26'd0});

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(done === 1'b0, "R1", "done in reset", {31'd0, done}, 32'd0);
        chk(imem_addr === 32'd0, "R1", "pc in reset", imem_addr, 32'd0);
        chk(!dmem_re && !dmem_we, "R1", "strobes in reset", {30'd0, dmem_re, dmem_we}, 32'd0);
        @(posedge clk);
        rst <= 1'b0;

        run_to_done(fin_ok);
        repeat (10) @(negedge clk);
        chk(done === 1'b1, "R10", "done sticky", {31'd0, done}, 32'd1);
        chk(imem_addr === 32'd200, "R10", "halt address", imem_addr, 32'd200);

        mchk("R3", 64, 32'd2);
        mchk("R3", 65, 32'd8);
        mchk("R3", 66, 32'd5);
        mchk("R3", 67, 32'hFFFF_FFFD);
        mchk("R3", 68, 32'hFFFF_FFF8);
        mchk("R4", 69, 32'h0000_00F5);
        mchk("R4", 70, 32'h0000_7FFD);
        mchk("R2", 71, 32'hFFFF_FFF0);
        mchk("R4", 72, 32'hFFFF_FFFE);
        mchk("R5", 73, 32'd16);
        mchk("R9", 74, 32'd0);
        mchk("R7", 75, 32'd0);
        mchk("R7", 76, 32'd2);
        mchk("R7", 77, 32'd3);
        mchk("R11", 78, 32'd0);
        mchk("R5", 79, 32'h1234_5678);
        mchk("R5", 80, 32'h1234_5678);
        mchk("R2", 81, 32'h1234_5678);
        mchk("R7", 82, 32'd7);
        mchk("R7", 83, 32'd0);

        // R1: reset after halt restarts at address 0
        @(posedge clk);
        rst <= 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(done === 1'b0, "R1", "done after reset", {31'd0, done}, 32'd0);
        chk(imem_addr === 32'd0, "R1", "pc after reset", imem_addr, 32'd0);
        @(posedge clk);
        rst <= 1'b0;
        run_to_done(fin_ok);
        mchk("R3", 73, 32'd16);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule